// File: doc/BRIEF.md
# Counter-Mode Initialization Vector Register

This block holds the 128-bit initialization vector of a block-cipher unit. Software loads it as four 32-bit words over the register bus. Word `k` occupies bits `32k+31:32k` of the vector, and bytes are stored little-endian: byte `n` of the vector sits at bits `8n+7:8n`. Each word records that it has been written. The vector counts as valid once every word has been written since the last reset or clear, whatever the order of the writes. Writes that arrive while the cipher unit is busy are dropped.

The cipher control sends a one-cycle consume pulse after it has used the current vector, and the block then updates the vector in place. What the update does depends on the chaining mode:

- **Counter mode:** the vector is incremented as a big-endian 128-bit integer. Byte 0 is the most significant byte and byte 15 is the least significant. The increment wraps at 2^128.
- **CBC, CFB and OFB modes:** the update loads a next-vector value supplied by the datapath.
- **Plain block mode:** the vector is left unchanged.

A clear trigger overwrites the vector with pseudo-random data and withdraws its valid status.

Top module: `ctr_iv_store`

## Requirements
- R1: While reset is active and in the first cycle after it, `iv_o` is zero and `iv_valid_o` is 0.
- R2: A write with `idle_i`=1 and `wr_idx_i`=k places `wr_data_i` into bits `32k+31:32k` of `iv_o` in the cycle after the write, and leaves the other words unchanged.
- R3: A write with `idle_i`=0 changes neither `iv_o` nor `iv_valid_o`.
- R4: `iv_valid_o` goes to 1 only once all four words have been written while idle since the last reset or clear, in any order. Rewriting a word does not clear the written status of the other words. A consume pulse does not change `iv_valid_o`.
- R5: A consume pulse with `mode_i`=4 (counter) adds one to the vector read as a big-endian integer. Byte 15 (bits 127:120) is least significant, and a carry moves from byte n to byte n-1.
- R6: In counter mode, an all-ones vector becomes all-zeros on a consume pulse.
- R7: A consume pulse with `mode_i`=1 (CBC), 2 (CFB) or 3 (OFB) loads `next_iv_i` into the vector on the next cycle.
- R8: A consume pulse with `mode_i`=0 (plain block) or any code from 5 to 7 leaves the vector unchanged.
- R9: `clear_i` loads `prd_i` into the vector and clears all written flags on the next cycle. It takes precedence over a consume pulse or a write in the same cycle.
- R10: A consume pulse takes precedence over a write in the same cycle, and that write is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | Cipher unit is idle; software writes are accepted only when it is 1 |
| mode_i | input | 3 | Chaining mode: 0 plain block, 1 CBC, 2 CFB, 3 OFB, 4 counter |
| wr_en_i | input | 1 | Software word write strobe |
| wr_idx_i | input | 2 | Index of the word being written |
| wr_data_i | input | 32 | Data of the word being written |
| consume_i | input | 1 | One-cycle pulse: the current vector has been used |
| next_iv_i | input | 128 | Next vector supplied by the datapath in CBC, CFB and OFB modes |
| clear_i | input | 1 | Overwrite the vector with pseudo-random data |
| prd_i | input | 128 | Pseudo-random data used by a clear |
| iv_o | output | 128 | Current vector, bytes stored little-endian |
| iv_valid_o | output | 1 | All four words have been written since the last reset or clear |

## Verification
The assertions assume that `consume_i`, `clear_i` and `wr_en_i` are sampled only on clock edges, and that `mode_i`, `next_iv_i` and `prd_i` are steady in any cycle that carries a pulse. They do not assume any protocol ordering between the consume pulse and `idle_i`. The stimulus changes inputs only on falling edges and holds every pulse for exactly one cycle. It also applies deliberately illegal overlaps (a clear together with a consume and a write, or a consume together with a write) so that the precedence rules are exercised rather than assumed.

// File: rtl/ctr_iv_store.sv
module ctr_iv_store #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 idle_i,
  input  logic [2:0]                           mode_i,
  input  logic                                 wr_en_i,
  input  logic [$clog2(NUM_WORDS)-1:0]         wr_idx_i,
  input  logic [WORD_W-1:0]                    wr_data_i,
  input  logic                                 consume_i,
  input  logic [WORD_W*NUM_WORDS-1:0]          next_iv_i,
  input  logic                                 clear_i,
  input  logic [WORD_W*NUM_WORDS-1:0]          prd_i,
  output logic [WORD_W*NUM_WORDS-1:0]          iv_o,
  output logic                                 iv_valid_o
);
  localparam int IV_W  = WORD_W * NUM_WORDS;
  localparam int BYTES = IV_W / 8;

  localparam logic [2:0] MODE_BLK = 3'd0;
  localparam logic [2:0] MODE_CBC = 3'd1;
  localparam logic [2:0] MODE_CFB = 3'd2;
  localparam logic [2:0] MODE_OFB = 3'd3;
  localparam logic [2:0] MODE_CTR = 3'd4;

  logic [IV_W-1:0]      iv_q, iv_d;
  logic [NUM_WORDS-1:0] seen_q, seen_d;
  logic [IV_W-1:0]      cnt_be, cnt_be_inc, cnt_le_inc;
  logic                 wr_ok;

  // Counter mode reads the stored bytes in reverse order, so swap, add, swap back.
  for (genvar b = 0; b < BYTES; b++) begin : g_swap
    assign cnt_be[8*b +: 8]               = iv_q[IV_W-8-8*b +: 8];
    assign cnt_le_inc[IV_W-8-8*b +: 8]    = cnt_be_inc[8*b +: 8];
  end
  assign cnt_be_inc = cnt_be + {{(IV_W-1){1'b0}}, 1'b1};

  assign wr_ok = wr_en_i && idle_i && (32'(wr_idx_i) < NUM_WORDS);

  always_comb begin
    iv_d   = iv_q;
    seen_d = seen_q;
    if (clear_i) begin
      iv_d   = prd_i;
      seen_d = '0;
    end else if (consume_i) begin
      unique case (mode_i)
        MODE_CTR:                     iv_d = cnt_le_inc;
        MODE_CBC, MODE_CFB, MODE_OFB: iv_d = next_iv_i;
        default:                      iv_d = iv_q;
      endcase
    end else if (wr_ok) begin
      iv_d[32'(wr_idx_i)*WORD_W +: WORD_W] = wr_data_i;
      seen_d[wr_idx_i]                     = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iv_q   <= '0;
      seen_q <= '0;
    end else begin
      iv_q   <= iv_d;
      seen_q <= seen_d;
    end
  end

  assign iv_o       = iv_q;
  assign iv_valid_o = &seen_q;

  // R3
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !idle_i && !consume_i && !clear_i) |=> ($stable(iv_o) && $stable(iv_valid_o)));

  // R4
  valid_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iv_valid_o) |-> $past(wr_en_i && idle_i && !consume_i && !clear_i));

  // R4
  consume_keeps_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !clear_i) |=> $stable(iv_valid_o));

  // R6
  ctr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !clear_i && mode_i == MODE_CTR && &iv_o) |=> (iv_o == '0));

  // R7
  chain_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !clear_i && (mode_i == MODE_CBC || mode_i == MODE_CFB || mode_i == MODE_OFB))
    |=> (iv_o == $past(next_iv_i)));

  // R8
  block_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !clear_i && (mode_i == MODE_BLK || mode_i > MODE_CTR)) |=> $stable(iv_o));

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (iv_o == $past(prd_i) && !iv_valid_o));
endmodule

// File: tb/test_ctr_iv_store.sv
`timescale 1ns/1ps
module test_ctr_iv_store;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         idle = 1;
  logic [2:0]   mode = 0;
  logic         wr_en = 0;
  logic [1:0]   wr_idx = 0;
  logic [31:0]  wr_data = 0;
  logic         consume = 0;
  logic [127:0] next_iv = 0;
  logic         clear = 0;
  logic [127:0] prd = 0;
  logic [127:0] iv;
  logic         iv_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] mb [16];
  bit         mv [4];

  always #4 clk = ~clk;

  ctr_iv_store i_ctr_iv_store (
    .clk_i(clk), .rst_ni(rst_n), .idle_i(idle), .mode_i(mode),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .consume_i(consume), .next_iv_i(next_iv), .clear_i(clear), .prd_i(prd),
    .iv_o(iv), .iv_valid_o(iv_valid)
  );

  function automatic logic [127:0] model_iv();
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[8*k +: 8] = mb[k];
    return v;
  endfunction

  function automatic void model_load(input logic [127:0] v);
    for (int k = 0; k < 16; k++) mb[k] = v[8*k +: 8];
  endfunction

  function automatic void model_step();
    logic [8:0] sum;
    logic       carry;
    if (!rst_n) begin
      model_load('0);
      for (int w = 0; w < 4; w++) mv[w] = 0;
    end else if (clear) begin
      model_load(prd);
      for (int w = 0; w < 4; w++) mv[w] = 0;
    end else if (consume) begin
      if (mode == 4) begin
        carry = 1;
        for (int k = 15; k >= 0; k--) begin
          sum   = {1'b0, mb[k]} + {8'd0, carry};
          mb[k] = sum[7:0];
          carry = sum[8];
        end
      end else if (mode >= 1 && mode <= 3) begin
        model_load(next_iv);
      end
    end else if (wr_en && idle) begin
      for (int j = 0; j < 4; j++) mb[4*int'(wr_idx) + j] = wr_data[8*j +: 8];
      mv[wr_idx] = 1;
    end
  endfunction

  task automatic compare(input string tag);
    logic [127:0] e;
    logic         ev;
    e  = model_iv();
    ev = mv[0] & mv[1] & mv[2] & mv[3];
    checks++;
    if (iv !== e) begin
      errors++;
      $display("FAIL %s iv actual=%h expected=%h", tag, iv, e);
    end
    checks++;
    if (iv_valid !== ev) begin
      errors++;
      $display("FAIL %s iv_valid actual=%b expected=%b", tag, iv_valid, ev);
    end
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    wr_en = 0; consume = 0; clear = 0;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d, input string tag);
    wr_en = 1; wr_idx = idx; wr_data = d;
    cyc(tag);
  endtask

  task automatic eat(input logic [2:0] m, input string tag);
    mode = m; consume = 1;
    cyc(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_step();
    @(negedge clk);
    compare("R1_in_reset");
    cyc("R1_in_reset");
    rst_n = 1;
    cyc("R1_after_reset");

    // R2 / R4: out-of-order writes, valid rises only after the fourth
    wr(2, 32'hAABBCCDD, "R2_word2");
    wr(0, 32'h11223344, "R2_word0");
    wr(3, 32'h55667788, "R4_three_words");
    wr(1, 32'h99AA0011, "R4_all_words");

    // R3: busy writes ignored
    idle = 0;
    wr(1, 32'hDEADBEEF, "R3_busy");
    wr(3, 32'h0BADF00D, "R3_busy");
    idle = 1;
    cyc("R3_after");

    // R4: rewrite keeps valid
    wr(0, 32'h01020304, "R4_rewrite");

    // R5: counter increments, including carry from byte 15 into byte 14
    eat(4, "R5_ctr");
    eat(4, "R5_ctr");
    wr(3, 32'hFF000000, "R2_setup");
    eat(4, "R5_carry");
    wr(3, 32'hFFFFFF00, "R2_setup");
    wr(2, 32'hFFFFFFFF, "R2_setup");
    eat(4, "R5_long_carry");
    eat(4, "R5_ctr_after");

    // R6: wrap
    for (int w = 0; w < 4; w++) wr(w[1:0], 32'hFFFFFFFF, "R2_ones");
    eat(4, "R6_wrap");

    // R7: chaining loads
    next_iv = 128'h0F0E0D0C0B0A09080706050403020100;
    eat(1, "R7_cbc");
    next_iv = 128'hCAFEBABE_12345678_9ABCDEF0_0FEDCBA9;
    eat(2, "R7_cfb");
    next_iv = 128'h1;
    eat(3, "R7_ofb");

    // R8: no update modes
    next_iv = 128'hFFFF;
    eat(0, "R8_block");
    eat(6, "R8_code6");
    eat(7, "R8_code7");

    // R10: consume beats write
    mode = 4; consume = 1; wr_en = 1; wr_idx = 2; wr_data = 32'h77777777;
    cyc("R10_consume_vs_write");
    mode = 1; next_iv = 128'h5A5A; consume = 1; wr_en = 1; wr_idx = 0; wr_data = 32'h1;
    cyc("R10_load_vs_write");

    // R9: clear beats consume and write
    prd = 128'h3C3C_A5A5_0F0F_F0F0_1234_5678_9ABC_DEF0;
    clear = 1; consume = 1; mode = 4; wr_en = 1; wr_idx = 1; wr_data = 32'h2;
    cyc("R9_clear");
    wr(3, 32'h44444444, "R4_after_clear");
    wr(3, 32'h45454545, "R4_repeat_word");
    wr(0, 32'h1, "R4_partial");
    wr(1, 32'h2, "R4_partial");
    wr(2, 32'h3, "R4_refilled");
    prd = 128'h0;
    clear = 1;
    cyc("R9_clear_zero");

    // R1: reset in the middle of operation
    wr(0, 32'h12345678, "R2_pre_reset");
    rst_n = 0;
    cyc("R1_mid_reset");
    rst_n = 1;
    cyc("R1_released");

    finish_run();
  end
endmodule